// File: doc/BRIEF.md
# DMA Line-Splitting Request Sequencer

This block takes a single DMA transfer at a time, described by a starting byte address, a byte count and a direction (load or store), and turns it into a chain of memory transactions. None of these transactions crosses a cache-line boundary. Only the opening transaction may begin part-way into a line, and it ends no later than the end of that line. Every transaction after it starts on a line boundary and covers the smaller of the remaining byte count and one full line.

The block issues the transactions one at a time on a valid/ready request channel. While `mem_valid` is high and `mem_ready` is low, the block holds every payload field of the channel steady. A transaction counts as issued only on a cycle where both signals are high. The block does not present the next transaction until the response to the current one has arrived. For a load, that response is a full line of data, and the block copies the wanted bytes into its byte buffer. For a store, that response is an acknowledgement.

The transfer request itself is a plain strobe and has no ready signal. The requester watches `busy` and does not strobe while it is high. A strobe that breaks this rule, or any other malformed input, sets a sticky error flag and is otherwise dropped. On acceptance the block returns a transfer ID. When the last response has arrived, the block reports completion with that same ID.

Top module: `dma_split_seq`

## Requirements
- R1: A `req_valid` strobe while idle, with `req_kind` equal to 2'b01 (load) or 2'b10 (store) and `req_len` in 1..MAX_LEN, is accepted. In the next cycle `busy` is high and `acc_valid` pulses for one cycle. At the same time `acc_id` carries the transfer ID. IDs count up by one from 0 after reset.
- R2: The first transaction has `mem_paddr` equal to the start address. Its `mem_len` is the full length when (start mod LINE_BYTES) + length is at most LINE_BYTES, and LINE_BYTES − (start mod LINE_BYTES) otherwise.
- R3: Every later transaction has `mem_paddr` = start + bytes completed so far. That address is line aligned. Its `mem_len` is the smaller of the remaining bytes and LINE_BYTES.
- R4: While `mem_valid` is high and `mem_ready` is low, the payload is held stable. After a handshake `mem_valid` stays low until the matching response arrives. The next transaction appears in the cycle after that response.
- R5: For a store, `mem_write` is 1. Byte (line_off + i) of `mem_wdata` equals byte (bytes completed + i) of the `req_wdata` captured at acceptance, for i below `mem_len`. All other bytes are zero. line_off is the start offset for the first transaction and 0 afterwards. For a load, `mem_write` is 0.
- R6: On each load response, the block copies `mem_len` bytes of the returned line into `rd_data` at index bytes completed. The copy starts at line_off within the line. After completion, `rd_data` byte i holds the memory byte at start + i.
- R7: In the cycle after the response that completes the length, `done_valid` pulses for one cycle with `done_id` equal to the accepted ID. In that same cycle `busy` is low.
- R8: A `req_valid` strobe while busy is ignored and sets `err`. The running transfer continues unchanged.
- R9: A strobe with any other `req_kind`, or with `req_len` of 0 or above MAX_LEN, is rejected. It sets `err` and leaves the block idle.
- R10: A data return or acknowledgement that arrives while no response is awaited, or that is the wrong kind for the direction, is ignored and sets `err`.
- R11: `mem_line_addr` is `mem_paddr` with its low log2(LINE_BYTES) bits cleared.
- R12: After reset, `busy`, `mem_valid`, `acc_valid`, `done_valid` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transfer request strobe |
| req_kind | input | 2 | 01 load, 10 store, others illegal |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Byte count |
| req_wdata | input | MAX_LEN*8 | Store bytes, byte i at bits 8i+7:8i |
| busy | output | 1 | Transfer in progress |
| acc_valid | output | 1 | Acceptance pulse |
| acc_id | output | ID_W | ID of accepted transfer |
| mem_valid | output | 1 | Transaction valid |
| mem_ready | input | 1 | Transaction taken |
| mem_write | output | 1 | Transaction is a store |
| mem_paddr | output | ADDR_W | Transaction byte address |
| mem_line_addr | output | ADDR_W | Line-aligned address |
| mem_len | output | CLEN_W | Transaction byte count |
| mem_wdata | output | LINE_BYTES*8 | Store bytes at line positions |
| rsp_data_valid | input | 1 | Load data return |
| rsp_data | input | LINE_BYTES*8 | Returned line |
| rsp_ack | input | 1 | Store acknowledgement |
| done_valid | output | 1 | Completion pulse |
| done_id | output | ID_W | ID of completed transfer |
| rd_data | output | MAX_LEN*8 | Gathered load bytes |
| err | output | 1 | Sticky protocol error |

## Verification
A bad completed-byte count shows up on the request channel at the first transaction after the fault, as a wrong address or length. A bad count can also make `done_valid` fire a response too early or too late. A bad line offset shows within one transaction: for stores it moves the bytes in `mem_wdata`, and for loads it moves the bytes in `rd_data`, which the bench reads once `done_valid` has pulsed. A fault in the sequencing state shows up as `mem_valid` rising while a response is still awaited, as payload changes under back-pressure, or as a missing or misplaced completion pulse or `err` bit. The bench samples each of these in the cycle right after the edge that should cause it.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  localparam logic [1:0] KIND_LOAD  = 2'b01;
  localparam logic [1:0] KIND_STORE = 2'b10;
endpackage

// File: rtl/dma_chunk_calc.sv
module dma_chunk_calc #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int LEN_W      = 9,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = OFF_W + 1
) (
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  total_len,
  input  logic [LEN_W-1:0]  done_bytes,
  output logic [ADDR_W-1:0] chunk_addr,
  output logic [CLEN_W-1:0] chunk_len,
  output logic [OFF_W-1:0]  line_off
);
  localparam int SUM_W = LEN_W + OFF_W + 1;

  logic              first;
  logic [SUM_W-1:0]  off_w, len_w, done_w, line_w, rem_w, pick_w;

  assign first      = (done_bytes == '0);
  assign off_w      = SUM_W'(start_addr[OFF_W-1:0]);
  assign len_w      = SUM_W'(total_len);
  assign done_w     = SUM_W'(done_bytes);
  assign line_w     = SUM_W'(LINE_BYTES);
  assign rem_w      = len_w - done_w;
  assign chunk_addr = start_addr + ADDR_W'(done_bytes);
  assign line_off   = first ? start_addr[OFF_W-1:0] : '0;

  always_comb begin
    if (first) begin
      if (off_w + len_w <= line_w) pick_w = len_w;
      else                         pick_w = line_w - off_w;
    end else begin
      if (rem_w < line_w) pick_w = rem_w;
      else                pick_w = line_w;
    end
  end

  assign chunk_len = CLEN_W'(pick_w);
endmodule

// File: rtl/dma_byte_buf.sv
module dma_byte_buf #(
  parameter int MAX_LEN    = 256,
  parameter int LINE_BYTES = 64,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = OFF_W + 1,
  localparam int BIW       = $clog2(MAX_LEN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic [MAX_LEN*8-1:0]    load_bytes,
  input  logic                    merge_en,
  input  logic [LINE_BYTES*8-1:0] merge_line,
  input  logic [LEN_W-1:0]        lo_idx,
  input  logic [LEN_W-1:0]        hi_idx,
  input  logic [OFF_W-1:0]        line_off,
  input  logic [CLEN_W-1:0]       pack_len,
  output logic [MAX_LEN*8-1:0]    buf_flat,
  output logic [LINE_BYTES*8-1:0] pack_line
);
  logic [MAX_LEN-1:0][7:0]    buf_q, buf_nx, load_b;
  logic [LINE_BYTES-1:0][7:0] line_b, pack_b;

  assign load_b    = load_bytes;
  assign line_b    = merge_line;
  assign buf_flat  = buf_q;
  assign pack_line = pack_b;

  // gather: returned line bytes land at [lo_idx, hi_idx)
  always_comb begin
    int idx;
    buf_nx = buf_q;
    for (int k = 0; k < MAX_LEN; k++) begin
      idx = k - int'(lo_idx) + int'(line_off);
      if (merge_en && k >= int'(lo_idx) && k < int'(hi_idx))
        buf_nx[k] = line_b[idx[OFF_W-1:0]];
    end
    if (load_en) buf_nx = load_b;
  end

  // scatter: buffer bytes from lo_idx placed at line_off
  always_comb begin
    int pos;
    int src;
    for (int j = 0; j < LINE_BYTES; j++) begin
      pos = j - int'(line_off);
      src = int'(lo_idx) + pos;
      if (pos >= 0 && pos < int'(pack_len))
        pack_b[j] = buf_q[src[BIW-1:0]];
      else
        pack_b[j] = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) buf_q <= '0;
    else        buf_q <= buf_nx;
  end
endmodule

// File: rtl/dma_split_seq.sv
module dma_split_seq
  import dma_seq_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int MAX_LEN    = 256,
  parameter int ID_W       = 8,
  localparam int LEN_W     = $clog2(MAX_LEN + 1),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = OFF_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  input  logic [1:0]              req_kind,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [LEN_W-1:0]        req_len,
  input  logic [MAX_LEN*8-1:0]    req_wdata,
  output logic                    busy,
  output logic                    acc_valid,
  output logic [ID_W-1:0]         acc_id,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_write,
  output logic [ADDR_W-1:0]       mem_paddr,
  output logic [ADDR_W-1:0]       mem_line_addr,
  output logic [CLEN_W-1:0]       mem_len,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic                    rsp_data_valid,
  input  logic [LINE_BYTES*8-1:0] rsp_data,
  input  logic                    rsp_ack,
  output logic                    done_valid,
  output logic [ID_W-1:0]         done_id,
  output logic [MAX_LEN*8-1:0]    rd_data,
  output logic                    err
);
  seq_state_e              st_q;
  logic [ADDR_W-1:0]       start_q;
  logic [LEN_W-1:0]        len_q, done_q, iss_q;
  logic                    wr_q;
  logic [ID_W-1:0]         cur_id_q, id_ctr_q;
  logic                    acc_q, fin_q, err_q;

  logic                    kind_ok, len_ok, req_ok, rsp_hit, bad_rsp;
  logic [ADDR_W-1:0]       c_addr;
  logic [CLEN_W-1:0]       c_len;
  logic [OFF_W-1:0]        c_off;
  logic [LINE_BYTES*8-1:0] packed_line;

  assign kind_ok = (req_kind == KIND_LOAD) || (req_kind == KIND_STORE);
  assign len_ok  = (req_len != '0) && (req_len <= LEN_W'(MAX_LEN));
  assign req_ok  = req_valid && (st_q == ST_IDLE) && kind_ok && len_ok;
  assign rsp_hit = (st_q == ST_WAIT) && (wr_q ? rsp_ack : rsp_data_valid);
  assign bad_rsp = (rsp_data_valid && !((st_q == ST_WAIT) && !wr_q)) ||
                   (rsp_ack && !((st_q == ST_WAIT) && wr_q));

  dma_chunk_calc #(
    .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES), .LEN_W(LEN_W)
  ) u_calc (
    .start_addr (start_q),
    .total_len  (len_q),
    .done_bytes (done_q),
    .chunk_addr (c_addr),
    .chunk_len  (c_len),
    .line_off   (c_off)
  );

  dma_byte_buf #(
    .MAX_LEN(MAX_LEN), .LINE_BYTES(LINE_BYTES)
  ) u_buf (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (req_ok && (req_kind == KIND_STORE)),
    .load_bytes (req_wdata),
    .merge_en   (rsp_hit && !wr_q),
    .merge_line (rsp_data),
    .lo_idx     (done_q),
    .hi_idx     (iss_q),
    .line_off   (c_off),
    .pack_len   (c_len),
    .buf_flat   (rd_data),
    .pack_line  (packed_line)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      start_q  <= '0;
      len_q    <= '0;
      done_q   <= '0;
      iss_q    <= '0;
      wr_q     <= 1'b0;
      cur_id_q <= '0;
      id_ctr_q <= '0;
      acc_q    <= 1'b0;
      fin_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      acc_q <= 1'b0;
      fin_q <= 1'b0;
      if ((req_valid && !req_ok) || bad_rsp) err_q <= 1'b1;
      unique case (st_q)
        ST_IDLE: if (req_ok) begin
          start_q  <= req_addr;
          len_q    <= req_len;
          wr_q     <= (req_kind == KIND_STORE);
          done_q   <= '0;
          iss_q    <= '0;
          cur_id_q <= id_ctr_q;
          id_ctr_q <= id_ctr_q + 1'b1;
          acc_q    <= 1'b1;
          st_q     <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_ready) begin
          iss_q <= done_q + LEN_W'(c_len);
          st_q  <= ST_WAIT;
        end
        ST_WAIT: if (rsp_hit) begin
          done_q <= iss_q;
          if (iss_q == len_q) begin
            fin_q <= 1'b1;
            st_q  <= ST_IDLE;
          end else begin
            st_q  <= ST_ISSUE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy          = (st_q != ST_IDLE);
  assign acc_valid     = acc_q;
  assign acc_id        = cur_id_q;
  assign done_valid    = fin_q;
  assign done_id       = cur_id_q;
  assign err           = err_q;
  assign mem_valid     = (st_q == ST_ISSUE);
  assign mem_write     = wr_q;
  assign mem_paddr     = c_addr;
  assign mem_line_addr = {c_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_len       = c_len;
  assign mem_wdata     = wr_q ? packed_line : '0;
endmodule

// File: rtl/dma_split_seq_chk.sv
module dma_split_seq_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CLEN_W    = OFF_W + 1,
  localparam int SW        = OFF_W + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              acc_valid,
  input logic              done_valid,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic              mem_write,
  input logic [ADDR_W-1:0] mem_paddr,
  input logic [CLEN_W-1:0] mem_len
);
  logic later_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                      later_q <= 1'b0;
    else if (done_valid)             later_q <= 1'b0;
    else if (mem_valid && mem_ready) later_q <= 1'b1;
  end

  a_r4_hold_payload: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_paddr) &&
                                $stable(mem_len) && $stable(mem_write));

  a_r2_within_line: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_len != '0) &&
      (SW'(mem_paddr[OFF_W-1:0]) + SW'(mem_len) <= SW'(LINE_BYTES)));

  a_r3_later_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && later_q |-> mem_paddr[OFF_W-1:0] == '0);

  a_r4_valid_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> busy);

  a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> !busy && !mem_valid);

  a_r1_pulse_excl: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_valid, done_valid}));
endmodule

bind dma_split_seq dma_split_seq_chk #(
  .ADDR_W(ADDR_W), .LINE_BYTES(LINE_BYTES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .acc_valid  (acc_valid),
  .done_valid (done_valid),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_write  (mem_write),
  .mem_paddr  (mem_paddr),
  .mem_len    (mem_len)
);

// File: tb/dma_split_seq_bench.sv
`timescale 1ns/1ps
module dma_split_seq_bench;
  localparam int LINE = 64;
  localparam int MAXL = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_kind = 2'b00;
  logic [31:0] req_addr = '0;
  logic [8:0] req_len = '0;
  logic [MAXL*8-1:0] req_wdata = '0;
  logic busy, acc_valid, mem_valid, mem_write, done_valid, err;
  logic [7:0] acc_id, done_id;
  logic mem_ready = 1'b0;
  logic [31:0] mem_paddr, mem_line_addr;
  logic [6:0] mem_len;
  logic [LINE*8-1:0] mem_wdata;
  logic rsp_data_valid = 1'b0;
  logic rsp_ack = 1'b0;
  logic [LINE*8-1:0] rsp_data = '0;
  logic [MAXL*8-1:0] rd_data;

  int nchk = 0;
  int nerr = 0;
  int cyc = 0;
  bit over = 1'b0;

  always #2 clk = ~clk;

  dma_split_seq u_dma_split_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .busy(busy), .acc_valid(acc_valid), .acc_id(acc_id),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_paddr(mem_paddr), .mem_line_addr(mem_line_addr), .mem_len(mem_len),
    .mem_wdata(mem_wdata), .rsp_data_valid(rsp_data_valid), .rsp_data(rsp_data),
    .rsp_ack(rsp_ack), .done_valid(done_valid), .done_id(done_id),
    .rd_data(rd_data), .err(err)
  );

  // {store, length, start address}
  localparam logic [48:0] VECS [0:6] = '{
    {1'b0, 16'd64,  32'h0000_1000},
    {1'b0, 16'd16,  32'h0000_1010},
    {1'b1, 16'd100, 32'h0000_1030},
    {1'b0, 16'd256, 32'h0000_2000},
    {1'b1, 16'd2,   32'h0000_203F},
    {1'b0, 16'd200, 32'h0000_3005},
    {1'b1, 16'd256, 32'h0000_4001}
  };

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8];
  endfunction

  function automatic logic [7:0] wpat(input int i, input int seed);
    return 8'((i * 29 + seed) & 255);
  endfunction

  task automatic chk(input bit ok, input string tag,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic start_req(input logic [31:0] a, input int len, input bit wr,
                           input int seed, input int eid);
    req_valid = 1'b1;
    req_kind  = wr ? 2'b10 : 2'b01;
    req_addr  = a;
    req_len   = 9'(len);
    for (int i = 0; i < MAXL; i++) req_wdata[8*i +: 8] = wpat(i, seed);
    @(negedge clk);
    req_valid = 1'b0;
    chk(acc_valid == 1'b1, "R1 acc_valid", 64'(acc_valid), 1);
    chk(acc_id == 8'(eid), "R1 acc_id", 64'(acc_id), 64'(eid));
    chk(busy == 1'b1, "R1 busy", 64'(busy), 1);
  endtask

  task automatic do_chunks(input logic [31:0] a, input int len, input bit wr,
                           input int seed, input int dly, input int eid);
    int done = 0;
    bit first = 1'b1;
    while (done < len) begin
      int off, clen;
      logic [31:0] pa;
      logic [LINE*8-1:0] ew;
      off  = first ? int'(a % LINE) : 0;
      clen = first ? ((off + len <= LINE) ? len : LINE - off)
                   : ((len - done < LINE) ? len - done : LINE);
      pa   = a + 32'(done);
      chk(mem_valid == 1'b1, "R4 next issued", 64'(mem_valid), 1);
      chk(mem_paddr == pa, first ? "R2 addr" : "R3 addr", 64'(mem_paddr), 64'(pa));
      chk(int'(mem_len) == clen, first ? "R2 len" : "R3 len", 64'(mem_len), 64'(clen));
      chk(mem_line_addr == {pa[31:6], 6'd0}, "R11 line addr",
          64'(mem_line_addr), 64'({pa[31:6], 6'd0}));
      chk(mem_write == wr, "R5 write flag", 64'(mem_write), 64'(wr));
      if (wr) begin
        for (int j = 0; j < LINE; j++)
          ew[8*j +: 8] = (j >= off && j < off + clen) ? wpat(done + j - off, seed) : 8'h00;
        chk(mem_wdata == ew, "R5 wdata placement", 64'(mem_wdata), 64'(ew));
      end
      for (int d = 0; d < dly; d++) begin
        @(negedge clk);
        chk(mem_valid && mem_paddr == pa, "R4 hold", 64'(mem_paddr), 64'(pa));
      end
      mem_ready = 1'b1;
      @(negedge clk);
      mem_ready = 1'b0;
      chk(mem_valid == 1'b0, "R4 one in flight", 64'(mem_valid), 0);
      @(negedge clk);
      chk(mem_valid == 1'b0, "R4 wait response", 64'(mem_valid), 0);
      if (wr) rsp_ack = 1'b1;
      else begin
        rsp_data_valid = 1'b1;
        for (int j = 0; j < LINE; j++) rsp_data[8*j +: 8] = mbyte({pa[31:6], 6'd0} + 32'(j));
      end
      @(negedge clk);
      rsp_ack = 1'b0;
      rsp_data_valid = 1'b0;
      done += clen;
      first = 1'b0;
      if (done < len) chk(done_valid == 1'b0, "R7 no early done", 64'(done_valid), 0);
    end
    chk(done_valid == 1'b1, "R7 done_valid", 64'(done_valid), 1);
    chk(done_id == 8'(eid), "R7 done_id", 64'(done_id), 64'(eid));
    chk(busy == 1'b0, "R7 idle", 64'(busy), 0);
    if (!wr) begin
      int bad = -1;
      for (int i = 0; i < len; i++)
        if (bad < 0 && rd_data[8*i +: 8] != mbyte(a + 32'(i))) bad = i;
      chk(bad < 0, "R6 gathered bytes", 64'(bad), 64'(-1));
    end
    @(negedge clk);
    chk(done_valid == 1'b0, "R7 single pulse", 64'(done_valid), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !over) begin
      over = 1'b1;
      nchk++;
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R12 reset values
    chk(!busy && !mem_valid && !acc_valid && !done_valid && !err, "R12 reset state",
        64'({busy, mem_valid, acc_valid, done_valid, err}), 0);

    for (int v = 0; v < 7; v++) begin
      logic [48:0] e;
      e = VECS[v];
      start_req(e[31:0], int'(e[47:32]), e[48], v * 5 + 1, v);
      do_chunks(e[31:0], int'(e[47:32]), e[48], v * 5 + 1, v % 3, v);
    end
    chk(err == 1'b0, "R10 clean run no err", 64'(err), 0);

    // R9 illegal kind
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b11; req_addr = 32'h100; req_len = 9'd4;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err && !busy && !acc_valid, "R9 bad kind rejected", 64'({err, busy}), 64'(2));

    // R9 zero and oversize length
    do_reset();
    req_valid = 1'b1; req_kind = 2'b01; req_len = 9'd0;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err && !busy, "R9 zero length", 64'({err, busy}), 64'(2));
    do_reset();
    req_valid = 1'b1; req_kind = 2'b10; req_len = 9'd300;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err && !busy, "R9 oversize length", 64'({err, busy}), 64'(2));

    // R10 stray acknowledgement while idle
    do_reset();
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    chk(err && !busy && !done_valid, "R10 idle ack", 64'({err, busy}), 64'(2));

    // R10 wrong-kind response on a load
    do_reset();
    start_req(32'h5000, 8, 1'b0, 3, 0);
    mem_ready = 1'b1;
    @(negedge clk);
    mem_ready = 1'b0;
    rsp_ack = 1'b1;
    @(negedge clk);
    rsp_ack = 1'b0;
    chk(err && busy && !mem_valid && !done_valid, "R10 wrong kind ignored",
        64'({err, busy, mem_valid, done_valid}), 64'(12));
    rsp_data_valid = 1'b1;
    for (int j = 0; j < LINE; j++) rsp_data[8*j +: 8] = mbyte(32'h5000 + 32'(j));
    @(negedge clk);
    rsp_data_valid = 1'b0;
    chk(done_valid && !busy, "R10 completes after stray", 64'({done_valid, busy}), 64'(2));
    chk(rd_data[63:0] == {mbyte(32'h5007), mbyte(32'h5006), mbyte(32'h5005), mbyte(32'h5004),
                          mbyte(32'h5003), mbyte(32'h5002), mbyte(32'h5001), mbyte(32'h5000)},
        "R6 short load", rd_data[63:0], 0);

    // R8 request while busy
    do_reset();
    @(negedge clk);
    start_req(32'h6010, 90, 1'b1, 9, 0);
    req_valid = 1'b1; req_kind = 2'b01; req_addr = 32'h9999; req_len = 9'd5;
    @(negedge clk);
    req_valid = 1'b0;
    chk(err == 1'b1, "R8 err on busy request", 64'(err), 1);
    chk(acc_valid == 1'b0, "R8 not accepted", 64'(acc_valid), 0);
    do_chunks(32'h6010, 90, 1'b1, 9, 0, 0);

    over = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule